// File: doc/BRIEF.md
# Memory-to-Memory Add Sequencer

This block computes W = X + Y where X, Y and W are addresses into a small internal byte memory. It does not add in one combinational step. A control sequencer walks through ten steps, and each step asserts one control strobe:

1. Load the X address into the memory address register.
2. Fetch.
3. Copy the memory data register into working register R1.
4. Load the Y address.
5. Fetch.
6. Copy the data register into R2.
7. Add R1 and R2 into R3.
8. Copy R3 into the data register.
9. Load the W address.
10. Store.

The memory takes a fixed number of cycles to complete each fetch or store. The sequencer waits on the memory's completion flag before it continues.

A user sets the three addresses and pulses `start` while the block is idle. The addresses are captured on that pulse. `busy` stays high for the whole sequence. `done` then pulses for one cycle. A back-door port lets a testbench preload any cell and read any cell while the block is idle.

Top module: `mm_add_seq`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: A `start` pulse while idle captures `addrX`, `addrY` and `addrW`, and `busy` is 1 from the next cycle.
- R3: When the sequence ends, cell W holds (cell X + cell Y) and every other cell is unchanged.
- R4: The sum wraps modulo 256, so only the low 8 bits are stored.
- R5: When W equals X or W equals Y, the operand cell is overwritten, and a later back-door read of it returns the sum.
- R6: When X equals Y, cell W receives twice the operand, modulo 256.
- R7: `busy` stays high until the store completes. `done` is then 1 for exactly one cycle while `busy` is 0.
- R8: A `start` received while `busy` is ignored. No new addresses are captured, exactly one `done` follows, and memory reflects only the first operation.
- R9: At most one step strobe is active in any cycle.
- R10: Each fetch and each store waits for the memory's completion flag, which comes MEM_LAT+1 cycles after the command. A whole operation therefore keeps `busy` high for 3*MEM_LAT+13 cycles (19 with the default of 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that starts an operation |
| addrX | input | 4 | Address of the first operand |
| addrY | input | 4 | Address of the second operand |
| addrW | input | 4 | Address of the result |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse when the store has completed |
| bdWe | input | 1 | Back-door write enable |
| bdAddr | input | 4 | Back-door address |
| bdWData | input | 8 | Back-door write data |
| bdRData | output | 8 | Back-door read data (combinational) |

## Verification
The add is tried with three kinds of operands:

- **Distinct addresses with small values.** These show that the right cells are read and only the target cell is written.
- **Operands whose sum exceeds 255.** These separate a wrapping 8-bit result from a truncated or saturated one.
- **Aliased addresses.** W equal to X, W equal to Y, and X equal to Y show whether the fetches finish before the store and whether one cell can feed both operands.

A start pulse with different addresses is injected mid-run. This tells apart a sequencer that ignores the pulse from one that restarts, or re-latches the addresses. The busy-cycle count of every run checks the wait on the memory's completion flag.

// File: rtl/mmadd_pkg.sv
package mmadd_pkg;
  typedef struct packed {
    logic capAddr;
    logic marX;
    logic fetch;
    logic toR1;
    logic marY;
    logic toR2;
    logic add;
    logic r3ToMdr;
    logic marW;
    logic store;
  } steps_t;
endpackage

// File: rtl/mmadd_mem.sv
module mmadd_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] mar,
  input  logic              fetch,
  input  logic              store,
  input  logic              mdrLd,
  input  logic [DATA_W-1:0] mdrIn,
  output logic [DATA_W-1:0] mdr,
  output logic              memDone,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [DATA_W-1:0] bdWData,
  output logic [DATA_W-1:0] bdRData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(MEM_LAT + 1);

  logic [DATA_W-1:0] cells [DEPTH];
  logic [CNT_W-1:0]  waitCnt;
  logic              opStore;

  assign bdRData = cells[bdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      opStore <= 1'b0;
      memDone <= 1'b0;
      mdr     <= '0;
    end else begin
      memDone <= 1'b0;
      if (fetch || store) begin
        waitCnt <= CNT_W'(MEM_LAT);
        opStore <= store;
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
        if (waitCnt == CNT_W'(1)) begin
          memDone <= 1'b1;
          if (!opStore) mdr <= cells[mar];
        end
      end
      if (mdrLd) mdr <= mdrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (waitCnt == CNT_W'(1) && opStore) cells[mar] <= mdr;
    else if (bdWe) cells[bdAddr] <= bdWData;
  end
endmodule

// File: rtl/mmadd_dp.sv
module mmadd_dp
  import mmadd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  steps_t            steps,
  input  logic [ADDR_W-1:0] addrX,
  input  logic [ADDR_W-1:0] addrY,
  input  logic [ADDR_W-1:0] addrW,
  output logic              memDone,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [DATA_W-1:0] bdWData,
  output logic [DATA_W-1:0] bdRData
);
  logic [ADDR_W-1:0] latX, latY, latW, mar;
  logic [DATA_W-1:0] r1, r2, r3, mdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latX <= '0; latY <= '0; latW <= '0; mar <= '0;
      r1 <= '0; r2 <= '0; r3 <= '0;
    end else begin
      if (steps.capAddr) begin
        latX <= addrX; latY <= addrY; latW <= addrW;
      end
      if (steps.marX) mar <= latX;
      if (steps.marY) mar <= latY;
      if (steps.marW) mar <= latW;
      if (steps.toR1) r1 <= mdr;
      if (steps.toR2) r2 <= mdr;
      if (steps.add)  r3 <= r1 + r2;
    end
  end

  mmadd_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) uMem (
    .clk(clk), .rstN(rstN), .mar(mar),
    .fetch(steps.fetch), .store(steps.store),
    .mdrLd(steps.r3ToMdr), .mdrIn(r3), .mdr(mdr), .memDone(memDone),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdWData(bdWData), .bdRData(bdRData)
  );
endmodule

// File: rtl/mmadd_ctrl.sv
module mmadd_ctrl
  import mmadd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   memDone,
  output steps_t steps,
  output logic   busy,
  output logic   done
);
  typedef enum logic [3:0] {
    IDLE, MARX, FX, WX, R1, MARY, FY, WY, R2, ADD, MDR, MARW, ST, WST, FIN
  } state_t;

  state_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt   = state;
    steps = '0;
    unique case (state)
      IDLE: if (start) begin steps.capAddr = 1'b1; nxt = MARX; end
      MARX: begin steps.marX = 1'b1;    nxt = FX;   end
      FX:   begin steps.fetch = 1'b1;   nxt = WX;   end
      WX:   if (memDone) nxt = R1;
      R1:   begin steps.toR1 = 1'b1;    nxt = MARY; end
      MARY: begin steps.marY = 1'b1;    nxt = FY;   end
      FY:   begin steps.fetch = 1'b1;   nxt = WY;   end
      WY:   if (memDone) nxt = R2;
      R2:   begin steps.toR2 = 1'b1;    nxt = ADD;  end
      ADD:  begin steps.add = 1'b1;     nxt = MDR;  end
      MDR:  begin steps.r3ToMdr = 1'b1; nxt = MARW; end
      MARW: begin steps.marW = 1'b1;    nxt = ST;   end
      ST:   begin steps.store = 1'b1;   nxt = WST;  end
      WST:  if (memDone) nxt = FIN;
      FIN:  nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  assign busy = (state != IDLE) && (state != FIN);
  assign done = (state == FIN);
endmodule

// File: rtl/mm_add_seq.sv
module mm_add_seq
  import mmadd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addrX,
  input  logic [ADDR_W-1:0] addrY,
  input  logic [ADDR_W-1:0] addrW,
  output logic              busy,
  output logic              done,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [DATA_W-1:0] bdWData,
  output logic [DATA_W-1:0] bdRData
);
  steps_t steps;
  logic   memDone;

  mmadd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .memDone(memDone),
    .steps(steps), .busy(busy), .done(done)
  );

  mmadd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) uDp (
    .clk(clk), .rstN(rstN), .steps(steps),
    .addrX(addrX), .addrY(addrY), .addrW(addrW), .memDone(memDone),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdWData(bdWData), .bdRData(bdRData)
  );
endmodule

// File: rtl/mm_add_seq_chk.sv
module mm_add_seq_chk
  import mmadd_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   start,
  input logic   busy,
  input logic   done,
  input steps_t steps,
  input logic   memDone
);
  p_one_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(steps));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_busy_until_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !steps.capAddr);
  p_mem_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    (steps.fetch || steps.store) |=> !memDone);
endmodule

bind mm_add_seq mm_add_seq_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .steps(steps), .memDone(memDone)
);

// File: tb/tb_mm_add_seq.sv
module tb_mm_add_seq;
  localparam int LAT = 2;
  localparam int EXP_BUSY = 3 * LAT + 13;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, bdWe = 1'b0;
  logic [3:0] addrX = '0, addrY = '0, addrW = '0, bdAddr = '0;
  logic [7:0] bdWData = '0;
  logic busy, done;
  logic [7:0] bdRData;
  logic [7:0] model [16];
  int nRun = 0, nFail = 0, cycles = 0;

  always #5 clk = ~clk;

  mm_add_seq #(.MEM_LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .addrX(addrX), .addrY(addrY),
    .addrW(addrW), .busy(busy), .done(done), .bdWe(bdWe), .bdAddr(bdAddr),
    .bdWData(bdWData), .bdRData(bdRData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    nRun = nRun + 1;
    if (act != exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic poke(int a, int v);
    @(negedge clk);
    bdWe = 1'b1; bdAddr = 4'(a); bdWData = 8'(v);
    @(negedge clk);
    bdWe = 1'b0;
    model[a] = 8'(v);
  endtask

  task automatic checkMem(string req);
    for (int i = 0; i < 16; i++) begin
      bdAddr = 4'(i);
      #1;
      check(req, int'(bdRData), int'(model[i]));
    end
  endtask

  task automatic runOp(string req, int x, int y, int w, bit inject);
    int nBusy = 0, nDone = 0, guard = 0;
    @(negedge clk);
    addrX = 4'(x); addrY = 4'(y); addrW = 4'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (nDone == 0 && guard < 500) begin
      if (busy) nBusy++;
      if (inject && nBusy == 5) begin
        start = 1'b1; addrX = 4'((x + 3) % 16);
        addrY = 4'((y + 5) % 16); addrW = 4'((w + 7) % 16);
      end else start = 1'b0;
      @(negedge clk);
      guard++;
      if (done) begin
        nDone++;
        check({req, "/R7 busy low with done"}, int'(busy), 0);
      end
    end
    start = 1'b0;
    check({req, "/R10 busy cycles"}, nBusy, EXP_BUSY);
    @(negedge clk);
    check({req, "/R7 done one cycle"}, int'(done), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || busy) nDone++;
    end
    check({req, "/R8 single completion"}, nDone, 1);
    model[w] = 8'(model[x] + model[y]);
    checkMem(req);
  endtask

  task automatic tReset();
    #1;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
  endtask

  task automatic tBasic();
    poke(2, 20); poke(3, 22);
    runOp("R3 basic", 2, 3, 9, 1'b0);
    check("R3 value", int'(model[9]), 42);
  endtask

  task automatic tWrap();
    poke(4, 200); poke(5, 100);
    runOp("R4 wrap", 4, 5, 6, 1'b0);
    check("R4 value", int'(model[6]), 44);
  endtask

  task automatic tAlias();
    poke(7, 15); poke(8, 250);
    runOp("R5 W=X", 7, 8, 7, 1'b0);
    check("R5 W=X value", int'(model[7]), 9);
    poke(10, 1); poke(11, 2);
    runOp("R5 W=Y", 10, 11, 11, 1'b0);
    check("R5 W=Y value", int'(model[11]), 3);
  endtask

  task automatic tSame();
    poke(12, 130);
    runOp("R6 X=Y", 12, 12, 13, 1'b0);
    check("R6 value", int'(model[13]), 4);
  endtask

  task automatic tIgnore();
    poke(0, 33); poke(1, 44);
    runOp("R8 ignored start", 0, 1, 14, 1'b1);
  endtask

  task automatic tStartR2();
    @(negedge clk);
    addrX = 4'd0; addrY = 4'd1; addrW = 4'd15; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    model[15] = 8'(model[0] + model[1]);
    checkMem("R2 result");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'(i * 17 + 3);
    tReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    for (int i = 0; i < 16; i++) poke(i, model[i]);
    tBasic();
    tWrap();
    tAlias();
    tSame();
    tIgnore();
    tStartR2();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule